// File: doc/BRIEF.md
# Three-Phase Quarter-Wave Phase Generator

This block keeps the power-frequency phase of a three-phase modulator and turns it into table reads. A phase accumulator advances at a rate set by a 12-bit frequency word, a 3-bit range code and a 3-bit carrier divider code. One electrical cycle has 1536 steps, and the upper bits of the accumulator give the current step. Three phase taps, 512 steps apart, are each folded onto a 384-entry quarter-wave table. Each tap yields a table index and a sign. The external table returns one unsigned 8-bit sample per phase. The block then scales each sample by the amplitude word and applies the sign, which gives a signed sample for each phase.

The block also produces two kinds of feedback signal. The first is a sampling strobe, a square wave with one period per phase step. The second is three zero-phase pulses, one per phase, each high for one third of the electrical cycle. A low counter-run bit pins the red phase at 0 degrees. A zero frequency word stops the phase, which holds the motor in DC braking. The direction bit makes the accumulator count down instead of up, with no jump in phase.

Top module: `three_phase_gen`

## Requirements
- R1: While `rst_n` or `phase_run` is low at a clock edge, the phase step is cleared to 0. The next edge then shows table indices red=0, yellow=256, blue=255, with the zero pulses (red, yellow, blue) = (0, 1, 0).
- R2: The accumulator gains pfs·2^min(range_sel,6) units once every 2^min(carr_div_sel,5) clocks. One phase step is 2^19 units. At pfs=2048 and range_sel=6, the step rises once every 4 clocks when carr_div_sel=0. It rises once every 8 clocks when carr_div_sel=1, or when range_sel=5 with carr_div_sel=0.
- R3: With `dir_rev`=1 the accumulator counts down, and the step wraps from 0 to 1535. While running, the step never changes by more than one position per clock, modulo 1536.
- R4: A frequency word of zero leaves the phase step unchanged while running.
- R5: Step s maps to table index and sign as follows: 0–383 gives s, positive; 384–767 gives 767−s, positive; 768–1151 gives s−768, negative; 1152–1535 gives 1535−s, negative. Every index is below 384.
- R6: Phase order in `tbl_addr`, `tbl_data`, `sample_out` and `zero_pulse` is red (slice 0), yellow (slice 1), blue (slice 2). The yellow step is red−512 and the blue step is red+512, both modulo 1536.
- R7: Output magnitude is floor(d·A/255), where d is the returned sample. A = amp_word when overmod=0, and A = 255+amp_word when overmod=1. The sign from R5 is then applied, so the largest magnitude is 510.
- R8: `wss_out` is high during the second half of each phase step, which makes it a square wave with one period per step.
- R9: A zero pulse is high while that phase's step is in 1024–1535. This gives a 1:2 high-to-low ratio per cycle, and exactly one of the three pulses is high at any time.
- R10: `tbl_addr` and `zero_pulse` register the step one edge after it changes. The table is assumed to answer on the edge after an address. `sample_out` registers one edge after the sample returns, using `amp_word` and `overmod` as sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pfs_word | input | 12 | Frequency word, 0 stops the phase |
| range_sel | input | 3 | Range code, multiplier 2^code (codes above 6 act as 6) |
| carr_div_sel | input | 3 | Carrier divider code, divider 2^code (codes above 5 act as 5) |
| dir_rev | input | 1 | 1 counts the phase down (blue-yellow-red order) |
| phase_run | input | 1 | 0 holds red phase at 0 degrees |
| overmod | input | 1 | Adds full scale to the amplitude factor |
| amp_word | input | 8 | Amplitude, full scale 255 |
| tbl_data | input | 24 | Returned unsigned samples, 8 bits per phase |
| tbl_addr | output | 27 | Quarter-wave indices, 9 bits per phase |
| sample_out | output | 30 | Signed scaled samples, 10 bits per phase |
| wss_out | output | 1 | Sampling strobe |
| zero_pulse | output | 3 | Zero-phase pulses per phase |

## Verification
A phase change appears on `tbl_addr` and `zero_pulse` one edge after the accumulator moves. The matching scaled sample follows two edges later: one edge for the modelled table and one for the scaler. An amplitude change alone shows up after one edge. Every run check counts edges from the clock edge at which `phase_run` is released. With an exact step every 4 or 8 clocks, the expected index is known at a fixed edge. The bench therefore samples half a period after that edge, and again after two further edges for the scaled value.

// File: rtl/tpg_pkg.sv
// Shared constants and the step-to-table folding function.
// Assumes a 1536-step electrical cycle built from a 384-entry quarter wave.
package tpg_pkg;
    localparam int QTR    = 384;
    localparam int STEPS  = 4 * QTR;
    localparam int STEP_W = $clog2(STEPS);
    localparam int IDX_W  = $clog2(QTR);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             neg;
        logic             zpp;
    } tbl_ref_t;

    // Fold one cycle step onto the quarter table with sign and zero-pulse level.
    function automatic tbl_ref_t fold_step(input logic [STEP_W-1:0] s);
        tbl_ref_t r;
        int v;
        v = int'(s);
        if (v < QTR) begin
            r.idx = IDX_W'(v);
            r.neg = 1'b0;
        end else if (v < 2*QTR) begin
            r.idx = IDX_W'(2*QTR - 1 - v);
            r.neg = 1'b0;
        end else if (v < 3*QTR) begin
            r.idx = IDX_W'(v - 2*QTR);
            r.neg = 1'b1;
        end else begin
            r.idx = IDX_W'(STEPS - 1 - v);
            r.neg = 1'b1;
        end
        r.zpp = (v >= (2*STEPS)/3);
        return r;
    endfunction
endpackage

// File: rtl/tpg_phase_accum.sv
// Fractional phase accumulator with carrier prescaler.
// Adds pfs<<range once per prescaler tick; one step equals 2^(PFS_W+7) units.
// Assumes the increment stays below one step, so the step moves by at most one.
module tpg_phase_accum
    import tpg_pkg::*;
#(
    parameter int PFS_W  = 12,
    parameter int MAX_N  = 5,
    parameter int MAX_M  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dir_rev,
    input  logic [PFS_W-1:0]  pfs,
    input  logic [2:0]        range_sel,
    input  logic [2:0]        carr_sel,
    output logic [STEP_W-1:0] step,
    output logic              half
);
    localparam int FRAC_W = PFS_W + 7;
    localparam int PRE_W  = MAX_N + 1;

    logic [FRAC_W-1:0] frac;
    logic [PRE_W-1:0]  presc, lim;
    logic [2:0]        cc, mc;
    logic              tick;
    logic [FRAC_W-1:0] inc;
    logic [FRAC_W:0]   fsum, fdif;
    logic [STEP_W-1:0] step_up, step_dn;

    // Clamp codes, build tick and increment, precompute both step neighbours.
    always_comb begin
        cc      = (carr_sel > 3'(MAX_N))  ? 3'(MAX_N) : carr_sel;
        mc      = (range_sel > 3'(MAX_M)) ? 3'(MAX_M) : range_sel;
        lim     = PRE_W'((1 << cc) - 1);
        tick    = (presc == lim);
        inc     = FRAC_W'(pfs) << mc;
        fsum    = {1'b0, frac} + {1'b0, inc};
        fdif    = {1'b0, frac} - {1'b0, inc};
        step_up = (step == STEP_W'(STEPS-1)) ? '0 : step + 1'b1;
        step_dn = (step == '0) ? STEP_W'(STEPS-1) : step - 1'b1;
    end

    // Advance or hold the phase; carry or borrow moves the step by one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            presc <= '0;
            frac  <= '0;
            step  <= '0;
        end else begin
            presc <= tick ? '0 : presc + 1'b1;
            if (tick) begin
                if (!dir_rev) begin
                    frac <= fsum[FRAC_W-1:0];
                    if (fsum[FRAC_W]) step <= step_up;
                end else begin
                    frac <= fdif[FRAC_W-1:0];
                    if (fdif[FRAC_W]) step <= step_dn;
                end
            end
        end
    end

    assign half = frac[FRAC_W-1];
endmodule

// File: rtl/tpg_quarter_map.sv
// One phase tap: offsets the shared step, folds it, registers index/sign/pulse.
// Assumes OFS < STEPS.
module tpg_quarter_map
    import tpg_pkg::*;
#(
    parameter int OFS = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step,
    output logic [IDX_W-1:0]  idx,
    output logic              neg,
    output logic              zpp
);
    localparam tbl_ref_t AT_ZERO = fold_step(STEP_W'(OFS));

    logic [STEP_W:0]   sum;
    logic [STEP_W-1:0] tap;
    tbl_ref_t          ref_c;

    // Rotate the step by this phase's offset and fold it.
    always_comb begin
        sum   = {1'b0, step} + (STEP_W+1)'(OFS);
        tap   = (sum >= (STEP_W+1)'(STEPS)) ? STEP_W'(sum - (STEP_W+1)'(STEPS))
                                            : STEP_W'(sum);
        ref_c = fold_step(tap);
    end

    // Register the tap outputs; reset shows the image of step zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= AT_ZERO.idx;
            neg <= AT_ZERO.neg;
            zpp <= AT_ZERO.zpp;
        end else begin
            idx <= ref_c.idx;
            neg <= ref_c.neg;
            zpp <= ref_c.zpp;
        end
    end
endmodule

// File: rtl/tpg_amp_scale.sv
// Scales a returned table sample by amplitude/full-scale and applies the sign.
// Assumes the sample arrives one edge after the sign it belongs to.
module tpg_amp_scale #(
    parameter int SAMP_W = 8,
    parameter int AMP_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     neg_in,
    input  logic [SAMP_W-1:0]        sample,
    input  logic [AMP_W-1:0]         amp,
    input  logic                     overmod,
    output logic signed [SAMP_W+1:0] out
);
    localparam int FULL   = (1 << AMP_W) - 1;
    localparam int EFF_W  = AMP_W + 1;
    localparam int PROD_W = SAMP_W + EFF_W;
    localparam int MAG_W  = SAMP_W + 1;

    logic              neg_d;
    logic [EFF_W-1:0]  eff;
    logic [PROD_W-1:0] prod, quo;
    logic [MAG_W-1:0]  mag;

    // Effective factor, product and truncating division by full scale.
    always_comb begin
        eff  = overmod ? EFF_W'(FULL) + EFF_W'(amp) : EFF_W'(amp);
        prod = PROD_W'(sample) * PROD_W'(eff);
        quo  = prod / PROD_W'(FULL);
        mag  = MAG_W'(quo);
    end

    // Align the sign with the returned sample, then register the signed result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_d <= 1'b0;
            out   <= '0;
        end else begin
            neg_d <= neg_in;
            out   <= neg_d ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
        end
    end
endmodule

// File: rtl/three_phase_gen.sv
// Top: phase accumulator, three folded taps 120 degrees apart, three scalers.
// Assumes an external quarter table with one clock of read latency.
module three_phase_gen
    import tpg_pkg::*;
#(
    parameter int PFS_W  = 12,
    parameter int AMP_W  = 8,
    parameter int SAMP_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PFS_W-1:0]      pfs_word,
    input  logic [2:0]            range_sel,
    input  logic [2:0]            carr_div_sel,
    input  logic                  dir_rev,
    input  logic                  phase_run,
    input  logic                  overmod,
    input  logic [AMP_W-1:0]      amp_word,
    input  logic [3*SAMP_W-1:0]   tbl_data,
    output logic [3*IDX_W-1:0]    tbl_addr,
    output logic [3*(SAMP_W+2)-1:0] sample_out,
    output logic                  wss_out,
    output logic [2:0]            zero_pulse
);
    localparam int NPH   = 3;
    localparam int OUT_W = SAMP_W + 2;
    localparam int LAG   = STEPS - STEPS / NPH;

    logic [STEP_W-1:0] red_step;
    logic [NPH-1:0]    neg_v;

    tpg_phase_accum #(.PFS_W(PFS_W)) accum_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (phase_run),
        .dir_rev   (dir_rev),
        .pfs       (pfs_word),
        .range_sel (range_sel),
        .carr_sel  (carr_div_sel),
        .step      (red_step),
        .half      (wss_out)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        localparam int OFS = (p * LAG) % STEPS;

        tpg_quarter_map #(.OFS(OFS)) map_i (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (red_step),
            .idx   (tbl_addr[p*IDX_W +: IDX_W]),
            .neg   (neg_v[p]),
            .zpp   (zero_pulse[p])
        );

        tpg_amp_scale #(.SAMP_W(SAMP_W), .AMP_W(AMP_W)) scale_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .neg_in  (neg_v[p]),
            .sample  (tbl_data[p*SAMP_W +: SAMP_W]),
            .amp     (amp_word),
            .overmod (overmod),
            .out     (sample_out[p*OUT_W +: OUT_W])
        );
    end
endmodule

// File: rtl/three_phase_gen_chk.sv
// Property checker bound to three_phase_gen; observes ports and the red step.
module three_phase_gen_chk
    import tpg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              phase_run,
    input logic [11:0]       pfs_word,
    input logic [STEP_W-1:0] red_step,
    input logic [3*IDX_W-1:0] tbl_addr,
    input logic [2:0]        zero_pulse,
    input logic [29:0]       sample_out
);
    logic [STEP_W-1:0] prev_step;
    logic              prev_ok;
    logic [STEP_W-1:0] dstep;

    // Remember last step and whether the last update was a running one.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ok <= 1'b0;
        else        prev_ok <= phase_run;
        prev_step <= red_step;
    end

    // Distance moved since last cycle, modulo the cycle length.
    always_comb begin
        dstep = (red_step >= prev_step) ? red_step - prev_step
                                        : STEP_W'(int'(red_step) + STEPS - int'(prev_step));
    end

    assert_hold_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_run |=> red_step == '0);

    assert_single_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok |-> (dstep == '0 || dstep == STEP_W'(1) || dstep == STEP_W'(STEPS-1)));

    assert_zero_freq_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_run && pfs_word == '0) |=> $stable(red_step));

    assert_index_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_addr[0 +: IDX_W] < IDX_W'(QTR) && tbl_addr[IDX_W +: IDX_W] < IDX_W'(QTR)
        && tbl_addr[2*IDX_W +: IDX_W] < IDX_W'(QTR));

    assert_out_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $signed(sample_out[0 +: 10]) >= -510 && $signed(sample_out[0 +: 10]) <= 510
        && $signed(sample_out[10 +: 10]) >= -510 && $signed(sample_out[10 +: 10]) <= 510
        && $signed(sample_out[20 +: 10]) >= -510 && $signed(sample_out[20 +: 10]) <= 510);

    assert_one_zero_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(zero_pulse) == 1);
endmodule

bind three_phase_gen three_phase_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_run  (phase_run),
    .pfs_word   (pfs_word),
    .red_step   (red_step),
    .tbl_addr   (tbl_addr),
    .zero_pulse (zero_pulse),
    .sample_out (sample_out)
);

// File: tb/three_phase_gen_tb_top.sv
`timescale 1ns/1ps
module three_phase_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] pfs_word;
    logic [2:0]  range_sel, carr_div_sel;
    logic        dir_rev, phase_run, overmod;
    logic [7:0]  amp_word;
    logic [23:0] tbl_data;
    logic [26:0] tbl_addr;
    logic [29:0] sample_out;
    logic        wss_out;
    logic [2:0]  zero_pulse;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    three_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .pfs_word(pfs_word), .range_sel(range_sel),
        .carr_div_sel(carr_div_sel), .dir_rev(dir_rev), .phase_run(phase_run),
        .overmod(overmod), .amp_word(amp_word), .tbl_data(tbl_data),
        .tbl_addr(tbl_addr), .sample_out(sample_out), .wss_out(wss_out),
        .zero_pulse(zero_pulse)
    );

    // Table model: registered read of a ramp scaled to 0..255.
    function automatic logic [7:0] rom_fn(input logic [8:0] a);
        return 8'((int'(a) * 2) / 3);
    endfunction

    always_ff @(posedge clk) begin
        for (int p = 0; p < 3; p++) tbl_data[p*8 +: 8] <= rom_fn(tbl_addr[p*9 +: 9]);
    end

    function automatic int addr_of(input int p);
        return int'(tbl_addr[p*9 +: 9]);
    endfunction

    function automatic int out_of(input int p);
        return int'($signed(sample_out[p*10 +: 10]));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Hold, apply settings, release at a negedge so the next edge is the first step.
    task automatic start_run(input logic [2:0] rs, input logic [2:0] cs, input logic dr);
        phase_run = 1'b0;
        pfs_word = 12'd2048; range_sel = rs; carr_div_sel = cs; dir_rev = dr;
        edges(2);
        phase_run = 1'b1;
    endtask

    // Vector entries: {overmod, amp, expected magnitude for a sample of 170}.
    localparam logic [18:0] VEC [7] = '{
        {1'b0, 8'd255, 10'd170}, {1'b0, 8'd0,   10'd0},   {1'b0, 8'd128, 10'd85},
        {1'b0, 8'd204, 10'd136}, {1'b1, 8'd0,   10'd170}, {1'b1, 8'd255, 10'd340},
        {1'b1, 8'd51,  10'd204}
    };

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hi, falls;
        logic prev;
        int held;
        rst_n = 1'b0; phase_run = 1'b0; pfs_word = '0; range_sel = '0;
        carr_div_sel = '0; dir_rev = 1'b0; overmod = 1'b0; amp_word = 8'd255;
        edges(5);
        rst_n = 1'b1;
        edges(3);

        // R1 / R6 / R9 / R8: held state image
        check("R1 red index", addr_of(0), 0);
        check("R6 yellow index", addr_of(1), 256);
        check("R6 blue index", addr_of(2), 255);
        check("R9 zero pulses at hold", int'(zero_pulse), 3'b010);
        check("R8 strobe at hold", int'(wss_out), 0);
        check("R7 red out at index 0", out_of(0), 0);

        // R7: amplitude vectors, yellow negative and blue positive, one edge latency
        for (int i = 0; i < 7; i++) begin
            overmod  = VEC[i][18];
            amp_word = VEC[i][17:10];
            edges(1);
            check("R7 blue scaled", out_of(2), int'(VEC[i][9:0]));
            check("R7 yellow scaled", out_of(1), -int'(VEC[i][9:0]));
        end
        overmod = 1'b0; amp_word = 8'd255;

        // R2 / R5 / R6: forward, one step per 4 clocks, step 100 shows after 401 edges
        start_run(3'd6, 3'd0, 1'b0);
        edges(401);
        check("R2 forward red index", addr_of(0), 100);
        check("R5 yellow folded index", addr_of(1), 356);
        check("R5 blue mirrored index", addr_of(2), 155);
        check("R9 zero pulses at step 100", int'(zero_pulse), 3'b010);
        edges(2);
        check("R10 red scaled two edges later", out_of(0), 66);

        // R8: strobe high half of every 4-clock step
        hi = 0;
        for (int i = 0; i < 400; i++) begin edges(1); hi += int'(wss_out); end
        check("R8 strobe duty", hi, 200);

        // R9: red pulse over one full cycle of 6144 clocks
        hi = 0; falls = 0; prev = zero_pulse[0];
        for (int i = 0; i < 6144; i++) begin
            edges(1);
            hi += int'(zero_pulse[0]);
            if (prev && !zero_pulse[0]) falls++;
            prev = zero_pulse[0];
        end
        check("R9 red pulse high count", hi, 2048);
        check("R9 red pulse falling edges", falls, 1);

        // R4: zero frequency word freezes the phase
        pfs_word = '0;
        edges(2);
        held = addr_of(0);
        edges(100);
        check("R4 index frozen", addr_of(0), held);

        // R1: counter-run low mid-run returns red to 0
        phase_run = 1'b0;
        edges(2);
        check("R1 hold mid-run", addr_of(0), 0);

        // R2: range code 5 halves the rate
        start_run(3'd5, 3'd0, 1'b0);
        edges(401);
        check("R2 range code 5", addr_of(0), 50);

        // R2: carrier code 1 ticks every second clock
        start_run(3'd6, 3'd1, 1'b0);
        edges(401);
        check("R2 carrier code 1", addr_of(0), 50);

        // R3 / R5 / R10: reverse borrows at once, step 1435 after 401 edges
        start_run(3'd6, 3'd0, 1'b1);
        edges(402);
        check("R3 reverse red index", addr_of(0), 100);
        check("R9 red pulse high in last third", int'(zero_pulse[0]), 1);
        edges(2);
        check("R5 reverse red negative", out_of(0), -66);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule